// File: doc/BRIEF.md
# Buffer RAM Read-Out Engine

The engine copies bytes out of a packet buffer RAM into a bank of 32 byte-wide read-back registers that a CPU can then read at leisure. The CPU drives it through a small register window. A control register holds two start commands. The general command copies a programmed number of bytes from a programmed 16-bit start address. The fixed-block command copies a mass-storage protocol block from a fixed buffer area. In the device role that block is the 31-byte command block, and in the host role it is the 13-byte status block. The fixed-block command ignores the address and count registers.

Each copy fills the read-back registers from index 0 upward. When every requested byte has landed, the engine drops the active start bit and sets a sticky completion interrupt in the same cycle. The CPU clears the interrupt by writing 1 to it. The RAM is synchronous with one cycle of read latency. The engine issues one address per cycle.

Window offsets: 0x00 control (bit 7 fixed-block start, bit 6 general start), 0x01 start address high byte, 0x02 start address low byte, 0x03 byte count, 0x04 status (bit 0 completion, write 1 to clear), 0x20 to 0x3F read-back registers 0 to 31.

Top module: `buf_rd_engine`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00, `irq_o` is 0 and every read-back register reads 0x00.
- R2: Control bits 5 to 0 always read 0. Writing 0 to both start bits starts nothing, and no RAM read follows.
- R3: Writing 1 to control bit 6 copies `count` bytes, starting at RAM address {addr_hi, addr_lo}, into read-back registers from index 0 upward. Bit 6 reads 1 while that copy runs.
- R4: A count above 32 is treated as 32, so exactly 32 RAM reads are made. A count of 0 makes no RAM read, leaves every read-back register unchanged, and still completes with the interrupt.
- R5: Writing 1 to control bit 7 while `host_mode_i` is 0 copies the 31 bytes starting at RAM address CMD_BASE into registers 0 to 30. The address and count registers are not used.
- R6: Writing 1 to control bit 7 while `host_mode_i` is 1 copies the 13 bytes starting at RAM address STS_BASE into registers 0 to 12.
- R7: If one write sets both bits 7 and 6, only the fixed-block copy runs. The control register reads 0x80 while it runs.
- R8: On completion, the active start bit clears and status bit 0 (`irq_o`) sets in the same cycle. The interrupt stays set until the CPU writes 1 to status bit 0.
- R9: A control write made while a copy is running is ignored. No second copy follows.
- R10: RAM reads happen only during a copy, at consecutive addresses, one per cycle.
- R11: Read-back registers with an index at or above the copy length keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 selects the host role, 0 the device role |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register window offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ram_re_o | output | 1 | RAM read enable |
| ram_addr_o | output | 16 | RAM read address |
| ram_rdata_i | input | 8 | RAM read data, valid one cycle after `ram_re_o` |
| irq_o | output | 1 | Sticky read-complete interrupt |

## Verification
A wrong remaining-count or address counter shows up at the read-back registers as shifted, missing or extra bytes. It also shows in the number of RAM strobes, which the bench counts for every copy. A capture index that lags or leads puts RAM data into the wrong register, and that is visible as soon as `irq_o` rises. A broken start or priority decode leaves the wrong area's pattern in the bank, or lets a second copy start. The bench sees the second copy a few tens of cycles after the ignored write, as an interrupt that reappears once it has been cleared.

// File: rtl/buf_rd_pkg.sv
package buf_rd_pkg;
  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_FIX = 1'b1
  } rd_mode_e;

  localparam logic [5:0] OFS_CTRL   = 6'h00;
  localparam logic [5:0] OFS_ADDR_H = 6'h01;
  localparam logic [5:0] OFS_ADDR_L = 6'h02;
  localparam logic [5:0] OFS_COUNT  = 6'h03;
  localparam logic [5:0] OFS_STAT   = 6'h04;

  localparam int CTRL_FIX_BIT = 7;
  localparam int CTRL_GEN_BIT = 6;
endpackage

// File: rtl/buf_rd_bank.sv
module buf_rd_bank #(
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(i)) regs_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];
endmodule

// File: rtl/buf_rd_seq.sv
module buf_rd_seq
  import buf_rd_pkg::*;
#(
  parameter int           AW       = 16,
  parameter int           NREG     = 32,
  parameter logic [AW-1:0] CMD_BASE = 16'h0040,
  parameter logic [AW-1:0] STS_BASE = 16'h0080,
  parameter int           CMD_LEN  = 31,
  parameter int           STS_LEN  = 13,
  localparam int          CW       = $clog2(NREG + 1),
  localparam int          IW       = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_gen_i,
  input  logic          start_fix_i,
  input  logic          host_mode_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [7:0]    count_i,
  output logic          busy_o,
  output rd_mode_e      mode_o,
  output logic          done_o,
  output logic          ram_re_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          cap_en_o,
  output logic [IW-1:0] cap_idx_o
);
  logic          busy_q, cap_v_q;
  rd_mode_e      mode_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q, len_gen, len_fix;
  logic [IW-1:0] issue_idx_q, cap_idx_q;
  logic          start;

  assign start   = (start_fix_i || start_gen_i) && !busy_q;
  assign len_gen = (count_i > 8'(NREG)) ? CW'(NREG) : CW'(count_i);
  assign len_fix = host_mode_i ? CW'(STS_LEN) : CW'(CMD_LEN);

  assign ram_re_o   = busy_q && (left_q != '0);
  assign ram_addr_o = addr_q;
  // last capture retired, nothing left to issue
  assign done_o     = busy_q && (left_q == '0) && !cap_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      mode_q      <= MODE_GEN;
      addr_q      <= '0;
      left_q      <= '0;
      issue_idx_q <= '0;
      cap_v_q     <= 1'b0;
      cap_idx_q   <= '0;
    end else begin
      cap_v_q   <= ram_re_o;
      cap_idx_q <= issue_idx_q;
      if (start) begin
        busy_q      <= 1'b1;
        issue_idx_q <= '0;
        if (start_fix_i) begin
          mode_q <= MODE_FIX;
          addr_q <= host_mode_i ? STS_BASE : CMD_BASE;
          left_q <= len_fix;
        end else begin
          mode_q <= MODE_GEN;
          addr_q <= base_addr_i;
          left_q <= len_gen;
        end
      end else if (busy_q) begin
        if (left_q != '0) begin
          addr_q      <= addr_q + 1'b1;
          left_q      <= left_q - 1'b1;
          issue_idx_q <= issue_idx_q + 1'b1;
        end
        if (done_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign mode_o    = mode_q;
  assign cap_en_o  = cap_v_q;
  assign cap_idx_o = cap_idx_q;
endmodule

// File: rtl/buf_rd_engine.sv
module buf_rd_engine
  import buf_rd_pkg::*;
#(
  parameter int            NREG     = 32,
  parameter logic [15:0]   CMD_BASE = 16'h0040,
  parameter logic [15:0]   STS_BASE = 16'h0080,
  parameter int            CMD_LEN  = 31,
  parameter int            STS_LEN  = 13,
  localparam int           IW       = $clog2(NREG)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_mode_i,
  input  logic        reg_we_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        ram_re_o,
  output logic [15:0] ram_addr_o,
  input  logic [7:0]  ram_rdata_i,
  output logic        irq_o
);
  logic [7:0]    addr_h_q, addr_l_q, count_q;
  logic          irq_q, busy, done, cap_en, go_fix, go_gen, ctrl_we;
  rd_mode_e      mode;
  logic [IW-1:0] cap_idx;
  logic [7:0]    bank_rd;

  assign ctrl_we = reg_we_i && reg_addr_i == OFS_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_h_q <= '0;
      addr_l_q <= '0;
      count_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == OFS_ADDR_H) addr_h_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == OFS_ADDR_L) addr_l_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == OFS_COUNT)  count_q  <= reg_wdata_i;
      // set wins over a simultaneous clear
      if (done) irq_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFS_STAT && reg_wdata_i[0]) irq_q <= 1'b0;
    end
  end

  buf_rd_seq #(
    .AW(16), .NREG(NREG), .CMD_BASE(CMD_BASE), .STS_BASE(STS_BASE),
    .CMD_LEN(CMD_LEN), .STS_LEN(STS_LEN)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_gen_i (ctrl_we && reg_wdata_i[CTRL_GEN_BIT]),
    .start_fix_i (ctrl_we && reg_wdata_i[CTRL_FIX_BIT]),
    .host_mode_i (host_mode_i),
    .base_addr_i ({addr_h_q, addr_l_q}),
    .count_i     (count_q),
    .busy_o      (busy),
    .mode_o      (mode),
    .done_o      (done),
    .ram_re_o    (ram_re_o),
    .ram_addr_o  (ram_addr_o),
    .cap_en_o    (cap_en),
    .cap_idx_o   (cap_idx)
  );

  buf_rd_bank #(.NREG(NREG)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cap_en),
    .wr_idx_i  (cap_idx),
    .wr_data_i (ram_rdata_i),
    .rd_idx_i  (reg_addr_i[IW-1:0]),
    .rd_data_o (bank_rd)
  );

  assign go_fix = busy && mode == MODE_FIX;
  assign go_gen = busy && mode == MODE_GEN;
  assign irq_o  = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[5]) reg_rdata_o = bank_rd;
    else begin
      unique case (reg_addr_i)
        OFS_CTRL:   reg_rdata_o = {go_fix, go_gen, 6'b0};
        OFS_ADDR_H: reg_rdata_o = addr_h_q;
        OFS_ADDR_L: reg_rdata_o = addr_l_q;
        OFS_COUNT:  reg_rdata_o = count_q;
        OFS_STAT:   reg_rdata_o = {7'b0, irq_q};
        default:    reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/buf_rd_chk.sv
module buf_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy,
  input logic        go_fix,
  input logic        go_gen,
  input logic        irq_o,
  input logic        ram_re_o,
  input logic [15:0] ram_addr_o,
  input logic        reg_we_i,
  input logic [5:0]  reg_addr_i,
  input logic [7:0]  reg_rdata_o
);
  // R2
  ctrl_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == 6'h00 |-> reg_rdata_o[5:0] == 6'b0);
  // R8
  irq_on_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> irq_o);
  // R8
  irq_rise_at_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(busy));
  // R10
  ram_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |-> busy);
  // R10
  ram_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o && $past(ram_re_o) |-> ram_addr_o == $past(ram_addr_o) + 16'd1);
  // R9
  start_from_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_we_i) && $past(reg_addr_i) == 6'h00);
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable({go_fix, go_gen}));
endmodule

bind buf_rd_engine buf_rd_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy        (busy),
  .go_fix      (go_fix),
  .go_gen      (go_gen),
  .irq_o       (irq_o),
  .ram_re_o    (ram_re_o),
  .ram_addr_o  (ram_addr_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/buf_rd_engine_test.sv
module buf_rd_engine_test;
  localparam logic [15:0] CMD_BASE = 16'h0040;
  localparam logic [15:0] STS_BASE = 16'h0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ram_re;
  logic [15:0] ram_addr;
  logic [7:0]  ram_rdata = '0;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  int          re_cnt = 0;

  always #5 clk = ~clk;

  buf_rd_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host_mode),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ram_re_o(ram_re), .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata), .irq_o(irq)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (ram_re) begin
      ram_rdata <= pat(ram_addr);
      re_cnt    <= re_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(req, {7'b0, irq}, 8'h01);
  endtask

  task automatic clear_irq();
    wr(6'h04, 8'h01);
  endtask

  task automatic prog(input logic [15:0] base, input logic [7:0] cnt);
    wr(6'h01, base[15:8]);
    wr(6'h02, base[7:0]);
    wr(6'h03, cnt);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(6'h00, d); chk("R1 ctrl", d, 8'h00);
    rd(6'h04, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 32; i++) begin
      rd(6'h20 + 6'(i), d); chk("R1 bank", d, 8'h00);
    end
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    re_cnt = 0;
    wr(6'h00, 8'h3F);
    rd(6'h00, d); chk("R2 reserved bits", d, 8'h00);
    repeat (10) @(negedge clk);
    chk("R2 no read", 8'(re_cnt), 8'h00);
    chk("R2 no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_general();
    logic [7:0] d;
    prog(16'h1234, 8'd5);
    re_cnt = 0;
    wr(6'h00, 8'h40);
    rd(6'h00, d); chk("R3 busy bit", d, 8'h40);
    wait_irq("R8 irq");
    rd(6'h00, d); chk("R8 go cleared", d, 8'h00);
    rd(6'h04, d); chk("R8 status", d, 8'h01);
    chk("R10 read count", 8'(re_cnt), 8'd5);
    for (int i = 0; i < 5; i++) begin
      rd(6'h20 + 6'(i), d); chk("R3 data", d, pat(16'h1234 + 16'(i)));
    end
    rd(6'h25, d); chk("R11 beyond", d, 8'h00);
    repeat (5) @(negedge clk);
    chk("R8 sticky", {7'b0, irq}, 8'h01);
    clear_irq();
    chk("R8 cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_busy_ignored();
    logic [7:0] d;
    prog(16'h0100, 8'd20);
    wr(6'h00, 8'h40);
    wr(6'h00, 8'h80);
    wait_irq("R9 first done");
    clear_irq();
    repeat (60) @(negedge clk);
    chk("R9 no second op", {7'b0, irq}, 8'h00);
    rd(6'h20, d); chk("R9 data", d, pat(16'h0100));
    rd(6'h33, d); chk("R9 data last", d, pat(16'h0113));
    rd(6'h34, d); chk("R11 beyond", d, 8'h00);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    prog(16'h3000, 8'd0);
    re_cnt = 0;
    wr(6'h00, 8'h40);
    wait_irq("R4 zero irq");
    chk("R4 zero reads", 8'(re_cnt), 8'h00);
    rd(6'h20, d); chk("R4 zero unchanged", d, pat(16'h0100));
    clear_irq();
  endtask

  task automatic t_clamp();
    logic [7:0] d;
    prog(16'h2000, 8'd200);
    re_cnt = 0;
    wr(6'h00, 8'h40);
    wait_irq("R4 clamp irq");
    repeat (3) @(negedge clk);
    chk("R4 clamp reads", 8'(re_cnt), 8'd32);
    rd(6'h20, d); chk("R4 first", d, pat(16'h2000));
    rd(6'h3F, d); chk("R4 last", d, pat(16'h201F));
    clear_irq();
  endtask

  task automatic t_fix_dev();
    logic [7:0] d;
    prog(16'h5555, 8'd3);
    host_mode = 1'b0;
    re_cnt = 0;
    wr(6'h00, 8'h80);
    rd(6'h00, d); chk("R5 busy bit", d, 8'h80);
    wait_irq("R5 irq");
    chk("R5 reads", 8'(re_cnt), 8'd31);
    for (int i = 0; i < 31; i++) begin
      rd(6'h20 + 6'(i), d); chk("R5 data", d, pat(CMD_BASE + 16'(i)));
    end
    rd(6'h3F, d); chk("R11 reg31 kept", d, pat(16'h201F));
    clear_irq();
  endtask

  task automatic t_fix_host();
    logic [7:0] d;
    host_mode = 1'b1;
    re_cnt = 0;
    wr(6'h00, 8'h80);
    wait_irq("R6 irq");
    chk("R6 reads", 8'(re_cnt), 8'd13);
    for (int i = 0; i < 13; i++) begin
      rd(6'h20 + 6'(i), d); chk("R6 data", d, pat(STS_BASE + 16'(i)));
    end
    rd(6'h2D, d); chk("R11 reg13 kept", d, pat(CMD_BASE + 16'd13));
    clear_irq();
    host_mode = 1'b0;
  endtask

  task automatic t_both();
    logic [7:0] d;
    prog(16'h7000, 8'd4);
    re_cnt = 0;
    wr(6'h00, 8'hC0);
    rd(6'h00, d); chk("R7 ctrl", d, 8'h80);
    wait_irq("R7 irq");
    chk("R7 reads", 8'(re_cnt), 8'd31);
    rd(6'h20, d); chk("R7 data", d, pat(CMD_BASE));
    rd(6'h3E, d); chk("R7 data last", d, pat(CMD_BASE + 16'd30));
    clear_irq();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_general();
    t_busy_ignored();
    t_zero();
    t_clamp();
    t_fix_dev();
    t_fix_host();
    t_both();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule